// File: doc/BRIEF.md
# Multi-Mode PWM Timer Channel

A 16-bit timer channel that turns one up-counter and four compare registers (A, B, C, D) into pulse-width-modulated waveforms on four output pins. A slow clock-enable tick feeds a power-of-two divider. A chosen edge of the selected divider tap advances the counter by one. One compare register, chosen by a clear-source field, resets the counter on match and so fixes the period.

There are two waveform modes. In the paired mode, registers A and B both steer pin A, and registers C and D both steer pin C. Pins B and D stay idle. In the per-register mode, each register steers its own pin. The pin of the period register is idle, and every driven pin falls back to its initial level when the period ends.

Software sets the channel up through a narrow write port: control, output levels, compare values and a counter preset. It then sets the start bit. Setting the start bit loads every pin with its initial level.

Top module: `pwm_timer_ch`

## Requirements
- R1: While the start bit is 1, the counter advances by one on each count event. While the start bit is 0, it holds its value.
- R2: The selected clock is bit `sel` of a tick divider, so it toggles every 2^sel ticks. The divider is cleared while the channel is stopped. Edge field 00 counts rising edges, 01 counts falling edges, and 1x counts both.
- R3: Clear-source codes 1, 2, 3 and 4 select register A, B, C and D. On a count event where the counter equals the selected register, the counter goes to 0 instead of advancing. Codes 0, 5, 6 and 7 leave the counter free-running, and it wraps from 0xFFFF to 0.
- R4: Mode code 4'h2 is paired mode, with pinEn = 4'b0101. Matches on A or B set pin A, and matches on C or D set pin C, each to that register's match level.
- R5: In paired mode, when both registers of a pair match on the same count event, B (or D) takes precedence over A (or C).
- R6: Mode code 4'h3 is per-register mode. Each pin is set to its own register's match level. The clear-source pin is undriven and low. When the period ends, each driven pin returns to its initial level, and this takes precedence over a same-event match.
- R7: Writing the start bit from 0 to 1 sets every pin to its initial level.
- R8: In any other mode code, all pins are undriven. An undriven pin always reads 0.
- R9: The write-port map is as follows. Address 0 holds presel[2:0], edge[4:3], clear[7:5] and mode[11:8]. Address 1 holds the levels: bit 2i is the initial level and bit 2i+1 is the match level of pin i (A=0 to D=3). Address 2 holds the start bit in bit 0. Address 3 presets the counter. Addresses 4 to 7 hold compare A to D.
- R10: After reset, the counter is 0, the channel is stopped, and all pins are undriven and low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| tick | input | 1 | Clock-enable tick feeding the divider |
| cntOut | output | 16 | Current counter value |
| pinOut | output | 4 | Output pin levels A..D |
| pinEn | output | 4 | Pin driven flags A..D |

## Verification
A corrupted pin state shows at pinOut within one count event of the compare that should have set it. It is checked by watching the counter reach the value just past each compare. A counter that skips, holds or misses its clear shows up at cntOut within one count event, or within one period for a missed clear. A divider or edge-select fault changes the number of increments in a fixed window of cycles, so the prescaler checks count increments rather than looking at single cycles.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;
  localparam int CNT_W   = 16;
  localparam int NUM_CMP = 4;
  localparam int SEL_W   = 3;
  localparam int LVL_W   = 2 * NUM_CMP;

  localparam logic [3:0] MODE_PAIRED = 4'h2;
  localparam logic [3:0] MODE_SPLIT  = 4'h3;

  // Strobes from control to datapath
  typedef struct packed {
    logic             countEn;
    logic             startLoad;
    logic             cntLoad;
    logic [CNT_W-1:0] loadVal;
  } ctlStrobe_t;

  // Static configuration the datapath needs
  typedef struct packed {
    logic [3:0]       mode;
    logic [2:0]       clrSel;
    logic [LVL_W-1:0] lvl;
  } chanCfg_t;
endpackage

// File: rtl/pwmt_ctrl.sv
`timescale 1ns/1ps
module pwmt_ctrl
  import pwmt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              tick,
  output chanCfg_t          cfg,
  output logic [CNT_W-1:0]  cmpVal [NUM_CMP],
  output ctlStrobe_t        strobe,
  output logic              run
);
  localparam int DIV_W = 1 << SEL_W;
  localparam int IDX_W = $clog2(NUM_CMP);
  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_LVL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_RUN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_CNT  = ADDR_W'(3);

  logic [SEL_W-1:0] presSel;
  logic [1:0]       edgeSel;
  logic [DIV_W-1:0] divCnt;
  logic             selClk;
  logic             selPrev;
  logic             edgeHit;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presSel <= '0;
      edgeSel <= '0;
      cfg     <= '0;
      run     <= 1'b0;
      for (int k = 0; k < NUM_CMP; k++) cmpVal[k] <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADR_CTRL) begin
        presSel    <= wrData[SEL_W-1:0];
        edgeSel    <= wrData[4:3];
        cfg.clrSel <= wrData[7:5];
        cfg.mode   <= wrData[11:8];
      end else if (wrAddr == ADR_LVL) begin
        cfg.lvl <= wrData[LVL_W-1:0];
      end else if (wrAddr == ADR_RUN) begin
        run <= wrData[0];
      end else if (wrAddr[ADDR_W-1]) begin
        cmpVal[wrAddr[IDX_W-1:0]] <= wrData;
      end
    end
  end

  // tick divider and edge detector
  assign selClk = divCnt[presSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      selPrev <= 1'b0;
    end else if (!run) begin
      divCnt  <= '0;
      selPrev <= 1'b0;
    end else begin
      if (tick) divCnt <= divCnt + DIV_W'(1);
      selPrev <= selClk;
    end
  end

  always_comb begin
    unique case (edgeSel)
      2'b00:   edgeHit = selClk & ~selPrev;
      2'b01:   edgeHit = ~selClk & selPrev;
      default: edgeHit = selClk ^ selPrev;
    endcase
  end

  // strobes toward the datapath
  always_comb begin
    strobe.countEn   = run & edgeHit;
    strobe.startLoad = wrEn && (wrAddr == ADR_RUN) && wrData[0] && !run;
    strobe.cntLoad   = wrEn && (wrAddr == ADR_CNT);
    strobe.loadVal   = wrData;
  end
endmodule

// File: rtl/pwmt_datapath.sv
`timescale 1ns/1ps
module pwmt_datapath
  import pwmt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanCfg_t         cfg,
  input  logic [CNT_W-1:0] cmpVal [NUM_CMP],
  input  ctlStrobe_t       strobe,
  output logic [CNT_W-1:0] cnt,
  output logic [NUM_CMP-1:0] pinOut,
  output logic [NUM_CMP-1:0] pinEn
);
  localparam int IDX_W = $clog2(NUM_CMP);

  logic [NUM_CMP-1:0] match;
  logic [NUM_CMP-1:0] pinState;
  logic [NUM_CMP-1:0] pinNxt;
  logic               clrValid;
  logic [IDX_W-1:0]   clrIdx;
  logic               clrHit;
  logic               isPaired;
  logic               isSplit;

  assign isPaired = (cfg.mode == MODE_PAIRED);
  assign isSplit  = (cfg.mode == MODE_SPLIT);
  assign clrValid = (cfg.clrSel >= 3'd1) && (32'(cfg.clrSel) <= NUM_CMP);
  assign clrIdx   = IDX_W'(cfg.clrSel - 3'd1);
  assign clrHit   = clrValid && match[clrIdx];

  // compare and counter
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign match[i] = strobe.countEn && (cnt == cmpVal[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.cntLoad) cnt <= strobe.loadVal;
    else if (strobe.countEn) cnt <= clrHit ? '0 : cnt + CNT_W'(1);
  end

  // per-pin waveform logic
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_pin
    localparam bit LEAD = (i % 2) == 0;
    localparam int PART = LEAD ? i + 1 : i;
    logic initLvl, hitLvl, partLvl, nxtBit, enBit;

    assign initLvl = cfg.lvl[2*i];
    assign hitLvl  = cfg.lvl[2*i+1];
    assign partLvl = cfg.lvl[2*PART+1];

    always_comb begin
      nxtBit = pinState[i];
      if (strobe.startLoad) begin
        nxtBit = initLvl;
      end else if (isPaired) begin
        if (LEAD) begin
          if (match[PART])   nxtBit = partLvl;
          else if (match[i]) nxtBit = hitLvl;
        end
      end else if (isSplit) begin
        if (clrHit)        nxtBit = initLvl;
        else if (match[i]) nxtBit = hitLvl;
      end
    end

    always_comb begin
      if (isPaired)     enBit = LEAD;
      else if (isSplit) enBit = !(clrValid && (clrIdx == IDX_W'(i)));
      else              enBit = 1'b0;
    end

    assign pinNxt[i] = nxtBit;
    assign pinEn[i]  = enBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinState <= '0;
    else       pinState <= pinNxt;
  end

  assign pinOut = pinState & pinEn;
endmodule

// File: rtl/pwm_timer_ch.sv
`timescale 1ns/1ps
module pwm_timer_ch
  import pwmt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [2:0]   wrAddr,
  input  logic [15:0]  wrData,
  input  logic         tick,
  output logic [15:0]  cntOut,
  output logic [3:0]   pinOut,
  output logic [3:0]   pinEn
);
  chanCfg_t         cfg;
  ctlStrobe_t       strobe;
  logic             run;
  logic [CNT_W-1:0] cmpVal [NUM_CMP];

  pwmt_ctrl #(.ADDR_W(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tick(tick), .cfg(cfg), .cmpVal(cmpVal), .strobe(strobe), .run(run)
  );

  pwmt_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .cmpVal(cmpVal), .strobe(strobe),
    .cnt(cntOut), .pinOut(pinOut), .pinEn(pinEn)
  );
endmodule

// File: rtl/pwmt_checker.sv
`timescale 1ns/1ps
module pwmt_checker
  import pwmt_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        run,
  input logic        countEn,
  input logic        cntLoad,
  input logic [3:0]  mode,
  input logic [2:0]  clrSel,
  input logic [15:0] cnt,
  input logic [3:0]  pinOut,
  input logic [3:0]  pinEn
);
  logic [3:0] clrMask;
  assign clrMask = 4'b0001 << (clrSel - 3'd1);

  p_hold_stopped_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !cntLoad) |=> $stable(cnt));

  p_step_or_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !cntLoad) |=> ((cnt == $past(cnt) + 16'd1) || (cnt == 16'd0)));

  p_paired_pins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PAIRED) |-> (pinEn == 4'b0101));

  p_period_pin_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_SPLIT) && (clrSel >= 3'd1) && (clrSel <= 3'd4)) |-> ((pinEn & clrMask) == 4'b0));

  p_other_mode_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((mode != MODE_PAIRED) && (mode != MODE_SPLIT)) |-> (pinEn == 4'b0));

  p_undriven_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut & ~pinEn) == 4'b0));
endmodule

bind pwm_timer_ch pwmt_checker u_chk (
  .clk(clk), .rstN(rstN), .run(run), .countEn(strobe.countEn),
  .cntLoad(strobe.cntLoad), .mode(cfg.mode), .clrSel(cfg.clrSel),
  .cnt(cntOut), .pinOut(pinOut), .pinEn(pinEn)
);

// File: tb/sim_pwm_timer_ch.sv
`timescale 1ns/1ps
module sim_pwm_timer_ch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        tick = 1'b0;
  logic [15:0] cntOut;
  logic [3:0]  pinOut;
  logic [3:0]  pinEn;

  int total = 0;
  int bad = 0;
  int tickMode = 0;
  bit done = 1'b0;

  pwm_timer_ch u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .tick(tick), .cntOut(cntOut), .pinOut(pinOut), .pinEn(pinEn));

  initial forever #2.5 clk = ~clk;

  // tick pattern: 0 every cycle, 1 alternate, 2 never
  initial forever begin
    @(negedge clk);
    if (tickMode == 0)      tick = 1'b1;
    else if (tickMode == 1) tick = ~tick;
    else                    tick = 1'b0;
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCnt(logic [15:0] v);
    int n = 0;
    while (cntOut !== v && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (n >= 500) chk("R3 wait timeout", cntOut, v);
  endtask

  // control word: presel, edge, clear, mode
  function automatic logic [15:0] ctl(int ps, int ed, int cl, int md);
    return 16'((md << 8) | (cl << 5) | (ed << 3) | ps);
  endfunction

  task automatic tReset();
    chk("R10 reset count", cntOut, 16'h0);
    chk("R10 reset pinEn", {12'h0, pinEn}, 16'h0);
    chk("R10 reset pinOut", {12'h0, pinOut}, 16'h0);
  endtask

  task automatic tPaired();
    wr(2, 0);
    wr(0, ctl(0, 2, 1, 2));
    wr(1, 16'h0028);
    wr(4, 9); wr(5, 4); wr(6, 2); wr(7, 6);
    wr(3, 0);
    chk("R9 paired enables", {12'h0, pinEn}, 16'h0005);
    wr(2, 1);
    waitCnt(3);  chk("R4 pin C after C match", {15'h0, pinOut[2]}, 16'h1);
    waitCnt(4);  chk("R4 pin A before B match", {15'h0, pinOut[0]}, 16'h0);
    waitCnt(5);  chk("R4 pin A after B match", {15'h0, pinOut[0]}, 16'h1);
    waitCnt(7);  chk("R4 pin C after D match", {15'h0, pinOut[2]}, 16'h0);
    chk("R4 pins B D idle", {12'h0, pinOut & 4'b1010}, 16'h0);
    waitCnt(0);  chk("R3 clear on A, pin A after A match", {15'h0, pinOut[0]}, 16'h0);
    waitCnt(1);  chk("R3 counts on after clear", cntOut, 16'h1);
  endtask

  task automatic tPriority();
    wr(2, 0);
    wr(0, ctl(0, 2, 0, 2));
    wr(1, 16'h0088);
    wr(4, 4); wr(5, 4); wr(6, 6); wr(7, 6);
    wr(3, 0);
    wr(2, 1);
    waitCnt(5);  chk("R5 B beats A", {15'h0, pinOut[0]}, 16'h1);
    waitCnt(7);  chk("R5 D beats C", {15'h0, pinOut[2]}, 16'h1);
  endtask

  task automatic tSplit();
    wr(2, 0);
    wr(0, ctl(0, 2, 4, 3));
    wr(1, 16'h001A);
    wr(4, 2); wr(5, 5); wr(6, 3); wr(7, 7);
    wr(3, 0);
    wr(2, 1);
    chk("R7 start loads initial", {12'h0, pinOut}, 16'h0004);
    chk("R6 period pin idle", {12'h0, pinEn}, 16'h0007);
    waitCnt(3);  chk("R6 pin A set", {12'h0, pinOut}, 16'h0005);
    waitCnt(4);  chk("R6 pin C cleared", {12'h0, pinOut}, 16'h0001);
    waitCnt(6);  chk("R6 pin B set", {12'h0, pinOut}, 16'h0003);
    waitCnt(0);  chk("R6 period return to initial", {12'h0, pinOut}, 16'h0004);
    wr(5, 7);
    waitCnt(7);  chk("R6 pin B not set before period", {15'h0, pinOut[1]}, 16'h0);
    waitCnt(1);  chk("R6 period beats same match", {15'h0, pinOut[1]}, 16'h0);
  endtask

  task automatic tStopWrap();
    logic [15:0] held;
    wr(2, 0);
    wr(0, ctl(0, 2, 7, 0));
    wr(1, 16'h00FF);
    wr(3, 16'hFFFC);
    wr(2, 1);
    chk("R8 other mode idle", {8'h0, pinEn, pinOut}, 16'h0);
    waitCnt(16'hFFFF);
    waitCnt(0);  chk("R3 free-run wrap", cntOut, 16'h0);
    wr(2, 0);
    held = cntOut;
    repeat (20) @(negedge clk);
    chk("R1 hold while stopped", cntOut, held);
  endtask

  task automatic measure(string req, int ps, int ed, int tm, int exp);
    logic [15:0] c0;
    wr(2, 0);
    tickMode = tm;
    wr(0, ctl(ps, ed, 0, 0));
    wr(3, 0);
    wr(2, 1);
    repeat (20) @(negedge clk);
    c0 = cntOut;
    repeat (64) @(negedge clk);
    chk(req, cntOut - c0, 16'(exp));
  endtask

  task automatic tPrescale();
    measure("R2 rising /8", 2, 0, 0, 8);
    measure("R2 falling /8", 2, 1, 0, 8);
    measure("R2 both /8", 2, 2, 0, 16);
    measure("R1 R2 both, half ticks", 0, 3, 1, 32);
    measure("R2 no ticks", 0, 2, 2, 0);
    tickMode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tPaired();
    tPriority();
    tSplit();
    tStopWrap();
    tPrescale();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule